// File: doc/BRIEF.md
# Configurable SPI-Mode Character Shifter

This block is the serial engine of a USART that runs as a synchronous SPI master. A parallel character of five to nine bits is handed over with a valid/ready handshake. The engine lowers an active-low select line and generates a serial clock whose idle level and sampling edge are programmable. It shifts the character out on the data-out line, most significant bit first. At the same time it captures the data-in line into a receive word, one bit per sampling edge. No framing bits are added: the wire carries only data bits.

Character length comes from a two-bit length code. A separate nine-bit override forces a nine-bit character whatever the code holds. The half-period of the serial clock is a programmable count of system clocks. The engine takes a snapshot of the whole configuration when it accepts a character, so the configuration inputs may change freely while a character is on the wire. When the last half-period has passed, select rises and a one-cycle receive pulse presents the captured character, right-aligned. In that same cycle the engine becomes ready again.

Top module: `spi_char_shifter`

## Requirements
- R1: A character is accepted on a rising clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is low from that edge until the character completes, and `tx_valid` while busy has no effect on the character in flight.
- R2: The length code selects 00=5, 01=6, 10=7 and 11=8 bits. With `cfg_nine` high the character is 9 bits long for every code. A character of N bits produces exactly 2N serial clock edges.
- R3: The transmitted bits are `tx_data[N-1]` down to `tx_data[0]`, in that order. Bits of `tx_data` above N-1 are never sent, and no start, parity or stop bit appears.
- R4: While idle, `sel_n_out` is high and `sclk_out` follows `cfg_cpol` with one cycle of delay. On acceptance the clock still sits at the polarity level.
- R5: With `cfg_cpha`=1, the first bit is on `txd_out` when select falls. Data is captured on odd clock edges (1, 3, ...) and changes on even ones. With `cfg_cpha`=0, data changes on odd edges and is captured on even edges.
- R6: With D = `cfg_half_div` (0 treated as 1), select falls at the accepting edge. Clock edge k follows k*D cycles later, and select rises (2N+1)*D cycles after acceptance. Select stays low throughout the character.
- R7: On completion, `rx_valid` is high for exactly one cycle. In that cycle select has just risen, `tx_ready` is high, and `rx_data[N-1:0]` holds the captured bits, first captured in bit N-1, with the bits above them zero.
- R8: Polarity, phase, length, nine-bit override and divider are all sampled at acceptance. Changing them during a character has no effect on that character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | 1: capture on first edge; 0: capture on second edge |
| cfg_len | input | 2 | Character length code (5 to 8 bits) |
| cfg_nine | input | 1 | Forces a 9-bit character |
| cfg_half_div | input | DIV_W | Serial clock half-period in system clocks |
| tx_valid | input | 1 | Transmit character offered |
| tx_data | input | DATA_W | Transmit character, right-aligned |
| tx_ready | output | 1 | Engine idle, character can be accepted |
| sclk_out | output | 1 | Serial clock |
| sel_n_out | output | 1 | Active-low slave select |
| txd_out | output | 1 | Serial data out |
| rxd_in | input | 1 | Serial data in |
| rx_valid | output | 1 | One-cycle pulse: received character ready |
| rx_data | output | DATA_W | Received character, right-aligned |

## Verification
Two events can share a clock edge. One is the completion tick, which raises select, pulses `rx_valid` and restores `tx_ready`. The other is the acceptance of a new character, which can fall on the very next edge. The bench provokes this by offering the next character in the same cycle the receive pulse is seen, with a different mode and length. It judges the outcome by checking that select is high for that single cycle only, that both characters arrive intact at the modelled slave, and that the edge count and timing of the second character match its own configuration, not that of the first.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;

  localparam int CHAR_MAX = 9;
  localparam int NB_W     = 4;

  typedef struct packed {
    logic            cpol;
    logic            cpha;
    logic [NB_W-1:0] nbits;
  } char_cfg_t;

  // length code 00..11 -> 5..8 bits, override -> 9 bits
  function automatic logic [NB_W-1:0] char_bits(input logic [1:0] len_code,
                                                input logic       nine);
    return nine ? NB_W'(CHAR_MAX) : (NB_W'(5) + NB_W'(len_code));
  endfunction

endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == (half_div - DIV_W'(1)));

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt_q <= '0;
    else                     cnt_q <= cnt_q + DIV_W'(1);
  end

endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         advance,
  output logic         msb
);

  logic [W-1:0] sreg_q;

  assign msb = sreg_q[W-1];

  always_ff @(posedge clk) begin
    if (rst)          sreg_q <= '0;
    else if (load)    sreg_q <= load_val;
    else if (advance) sreg_q <= {sreg_q[W-2:0], 1'b0};
  end

endmodule

// File: rtl/spi_rx_capture.sv
module spi_rx_capture #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         sample,
  input  logic         bit_in,
  output logic [W-1:0] word
);

  always_ff @(posedge clk) begin
    if (rst || clear) word <= '0;
    else if (sample)  word <= {word[W-2:0], bit_in};
  end

endmodule

// File: rtl/spi_char_shifter.sv
module spi_char_shifter
  import spi_shift_pkg::*;
#(
  parameter int DATA_W = CHAR_MAX,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_nine,
  input  logic [DIV_W-1:0]  cfg_half_div,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              sclk_out,
  output logic              sel_n_out,
  output logic              txd_out,
  input  logic              rxd_in,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data
);

  localparam int EDGE_W = $clog2(2 * DATA_W + 2);

  char_cfg_t         cfg_q, cfg_new;
  logic [DIV_W-1:0]  div_q;
  logic              busy_q;
  logic [EDGE_W-1:0] hcnt_q, edge_num, last_edge;
  logic              accept, tick, tx_msb;
  logic              clk_edge, final_tick, odd_edge, sample_edge, shift_edge;
  logic [NB_W-1:0]   pad;
  logic [DATA_W-1:0] aligned, load_val, rx_word;

  always_comb begin
    cfg_new.cpol  = cfg_cpol;
    cfg_new.cpha  = cfg_cpha;
    cfg_new.nbits = char_bits(cfg_len, cfg_nine);
    pad           = NB_W'(DATA_W) - cfg_new.nbits;
    aligned       = tx_data << pad;
    load_val      = cfg_cpha ? (aligned << 1) : aligned;
  end

  assign accept      = tx_valid && tx_ready;
  assign edge_num    = hcnt_q + EDGE_W'(1);
  assign last_edge   = EDGE_W'(cfg_q.nbits) << 1;
  assign clk_edge    = tick && (edge_num <= last_edge);
  assign final_tick  = tick && (edge_num == (last_edge + EDGE_W'(1)));
  assign odd_edge    = edge_num[0];
  assign sample_edge = clk_edge && (cfg_q.cpha == odd_edge);
  assign shift_edge  = clk_edge && (cfg_q.cpha != odd_edge);

  spi_half_tick #(.DIV_W(DIV_W)) i_tick (
    .clk      (clk),
    .rst      (rst),
    .run      (busy_q),
    .half_div (div_q),
    .tick     (tick)
  );

  spi_tx_shift #(.W(DATA_W)) i_tx (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (load_val),
    .advance  (shift_edge),
    .msb      (tx_msb)
  );

  spi_rx_capture #(.W(DATA_W)) i_rx (
    .clk    (clk),
    .rst    (rst),
    .clear  (accept),
    .sample (sample_edge),
    .bit_in (rxd_in),
    .word   (rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      tx_ready  <= 1'b1;
      sel_n_out <= 1'b1;
      sclk_out  <= cfg_cpol;
      txd_out   <= 1'b0;
      rx_valid  <= 1'b0;
      rx_data   <= '0;
      hcnt_q    <= '0;
      cfg_q     <= '0;
      div_q     <= DIV_W'(1);
    end else begin
      rx_valid <= 1'b0;
      if (!busy_q) begin
        sclk_out <= cfg_cpol;
        if (accept) begin
          busy_q    <= 1'b1;
          tx_ready  <= 1'b0;
          sel_n_out <= 1'b0;
          cfg_q     <= cfg_new;
          div_q     <= (cfg_half_div == '0) ? DIV_W'(1) : cfg_half_div;
          hcnt_q    <= '0;
          txd_out   <= cfg_cpha ? aligned[DATA_W-1] : 1'b0;
        end
      end else if (tick) begin
        hcnt_q <= edge_num;
        if (clk_edge)   sclk_out <= ~sclk_out;
        if (shift_edge) txd_out  <= tx_msb;
        if (final_tick) begin
          busy_q    <= 1'b0;
          tx_ready  <= 1'b1;
          sel_n_out <= 1'b1;
          rx_valid  <= 1'b1;
          rx_data   <= rx_word;
        end
      end
    end
  end

endmodule

// File: rtl/spi_char_shifter_chk.sv
module spi_char_shifter_chk
  import spi_shift_pkg::*;
#(
  parameter int DATA_W = CHAR_MAX,
  parameter int DIV_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_cpol,
  input logic              cfg_cpha,
  input logic [1:0]        cfg_len,
  input logic              cfg_nine,
  input logic [DIV_W-1:0]  cfg_half_div,
  input logic              tx_valid,
  input logic [DATA_W-1:0] tx_data,
  input logic              tx_ready,
  input logic              sclk_out,
  input logic              sel_n_out,
  input logic              txd_out,
  input logic              rxd_in,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data
);

  logic [5:0]      tog_cnt;
  logic            sclk_prev;
  logic [NB_W-1:0] exp_bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      tog_cnt   <= '0;
      sclk_prev <= 1'b0;
      exp_bits  <= NB_W'(5);
    end else if (tx_valid && tx_ready) begin
      tog_cnt   <= '0;
      sclk_prev <= cfg_cpol;
      exp_bits  <= char_bits(cfg_len, cfg_nine);
    end else begin
      sclk_prev <= sclk_out;
      if (sclk_out != sclk_prev) tog_cnt <= tog_cnt + 6'd1;
    end
  end

  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> (!tx_ready && !sel_n_out));

  a_r2_edge_count: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (tog_cnt == (6'(exp_bits) << 1)));

  a_r4_idle_clock: assert property (@(posedge clk) disable iff (rst)
    (sel_n_out && $past(sel_n_out)) |-> (sclk_out == $past(cfg_cpol)));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  a_r7_pulse_at_select_rise: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> ($rose(sel_n_out) && tx_ready));

  a_r7_upper_bits_zero: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> ((rx_data >> exp_bits) == '0));

endmodule

bind spi_char_shifter spi_char_shifter_chk #(.DATA_W(DATA_W), .DIV_W(DIV_W)) i_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_cpol     (cfg_cpol),
  .cfg_cpha     (cfg_cpha),
  .cfg_len      (cfg_len),
  .cfg_nine     (cfg_nine),
  .cfg_half_div (cfg_half_div),
  .tx_valid     (tx_valid),
  .tx_data      (tx_data),
  .tx_ready     (tx_ready),
  .sclk_out     (sclk_out),
  .sel_n_out    (sel_n_out),
  .txd_out      (txd_out),
  .rxd_in       (rxd_in),
  .rx_valid     (rx_valid),
  .rx_data      (rx_data)
);

// File: tb/test_spi_char_shifter.sv
`timescale 1ns/1ps
module test_spi_char_shifter;

  localparam int DW  = 9;
  localparam int DVW = 8;

  logic           clk = 1'b0;
  logic           rst;
  logic           cfg_cpol, cfg_cpha, cfg_nine;
  logic [1:0]     cfg_len;
  logic [DVW-1:0] cfg_half_div;
  logic           tx_valid;
  logic [DW-1:0]  tx_data;
  logic           tx_ready, sclk_out, sel_n_out, txd_out, rxd_in, rx_valid;
  logic [DW-1:0]  rx_data;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  spi_char_shifter #(.DATA_W(DW), .DIV_W(DVW)) i_spi_char_shifter (
    .clk(clk), .rst(rst), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_len(cfg_len), .cfg_nine(cfg_nine), .cfg_half_div(cfg_half_div),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .sclk_out(sclk_out), .sel_n_out(sel_n_out), .txd_out(txd_out),
    .rxd_in(rxd_in), .rx_valid(rx_valid), .rx_data(rx_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int char_len(input logic [1:0] len, input bit nine);
    return nine ? 9 : 5 + int'(len);
  endfunction

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // idle for k cycles, then check the quiet state
  task automatic idle(input int k);
    repeat (k) @(negedge clk);
    chk(sel_n_out == 1'b1 && tx_ready == 1'b1, "R4 idle select/ready",
        int'({sel_n_out, tx_ready}), 3);
    chk(sclk_out == cfg_cpol, "R4 idle clock level", int'(sclk_out), int'(cfg_cpol));
  endtask

  // must be called at a negedge with tx_ready high; returns at the rx_valid negedge
  task automatic run_char(input bit pol, input bit pha, input logic [1:0] len,
                          input bit nine, input int div, input logic [8:0] data,
                          input logic [8:0] pat, input bit disturb);
    int n, d, cnt, edges, first, idx, mask;
    bit prev, done, sel_bad;
    logic [8:0] got;
    n = char_len(len, nine);
    d = (div == 0) ? 1 : div;
    mask = (1 << n) - 1;
    cnt = 0; edges = 0; first = -1; done = 0; sel_bad = 0; got = '0;
    cfg_cpol = pol; cfg_cpha = pha; cfg_len = len; cfg_nine = nine;
    cfg_half_div = DVW'(div); tx_data = data; tx_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    chk(sel_n_out == 1'b0 && tx_ready == 1'b0, "R1 accept lowers select and ready",
        int'({sel_n_out, tx_ready}), 0);
    chk(sclk_out == pol, "R4 clock at polarity on accept", int'(sclk_out), int'(pol));
    prev = sclk_out;
    if (pha) rxd_in = pat[n-1];
    while (!done) begin
      @(negedge clk);
      cnt++;
      if (disturb && cnt == 2) begin
        cfg_cpol = ~pol; cfg_cpha = ~pha; cfg_len = ~len; cfg_nine = ~nine;
        cfg_half_div = DVW'(d + 3); tx_data = ~data; tx_valid = 1'b1;
      end
      if (disturb && cnt == 3) tx_valid = 1'b0;
      if (sclk_out != prev) begin
        edges++;
        prev = sclk_out;
        if (first < 0) first = cnt;
        if (pha == edges[0]) got = {got[7:0], txd_out};
        else begin
          idx = pha ? (n - 1 - edges / 2) : (n - 1 - (edges - 1) / 2);
          if (idx >= 0) rxd_in = pat[idx];
        end
      end
      if (rx_valid) done = 1;
      else if (sel_n_out) sel_bad = 1;
      if (cnt > 20000) begin
        chk(0, "R6 character never completed", cnt, (2 * n + 1) * d);
        done = 1;
      end
    end
    chk(int'(got) == (int'(data) & mask), "R3 bits seen by slave", int'(got), int'(data) & mask);
    chk(int'(rx_data) == (int'(pat) & mask), "R5 received word", int'(rx_data), int'(pat) & mask);
    chk(edges == 2 * n, "R2 serial clock edges", edges, 2 * n);
    chk(first == d, "R6 lead half-period", first, d);
    chk(cnt == (2 * n + 1) * d, "R6 character duration", cnt, (2 * n + 1) * d);
    chk(!sel_bad, "R6 select held low", int'(sel_bad), 0);
    chk(sel_n_out && tx_ready, "R7 pulse with select high and ready",
        int'({sel_n_out, tx_ready}), 3);
    if (disturb)
      chk(int'(got) == (int'(data) & mask) && edges == 2 * n,
          "R8 mid-character config change ignored", int'(got), int'(data) & mask);
    cfg_cpol = pol;
  endtask

  initial begin
    #(5.0 * 190000);
    chk(0, "R6 watchdog expired", 0, 1);
    report;
    $finish;
  end

  initial begin
    logic [1:0] len;
    void'($urandom(32'd4242));
    rst = 1'b1; cfg_cpol = 1'b1; cfg_cpha = 1'b0; cfg_len = 2'd0; cfg_nine = 1'b0;
    cfg_half_div = 8'd1; tx_valid = 1'b0; tx_data = '0; rxd_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sel_n_out && tx_ready && !rx_valid, "R4 reset state",
        int'({sel_n_out, tx_ready, rx_valid}), 6);
    chk(sclk_out == 1'b1, "R4 reset clock level", int'(sclk_out), 1);

    // all four modes, all four length codes
    for (int m = 0; m < 4; m++) begin
      for (int l = 0; l < 4; l++) begin
        len = 2'(l);
        run_char(m[1], m[0], len, 1'b0, l + 1, 9'($urandom), 9'($urandom), 1'b0);
        idle(2);
      end
    end
    // R2 nine-bit override with different length codes
    run_char(1'b0, 1'b1, 2'd0, 1'b1, 2, 9'h1A5, 9'h0F3, 1'b0);
    idle(1);
    run_char(1'b1, 1'b0, 2'd2, 1'b1, 1, 9'h15A, 9'h1C3, 1'b0);
    idle(1);
    // R6 divider zero behaves as one
    run_char(1'b0, 1'b0, 2'd3, 1'b0, 0, 9'h0AA, 9'h055, 1'b0);
    idle(1);
    // R3 upper bits above length ignored
    run_char(1'b1, 1'b1, 2'd0, 1'b0, 1, 9'h1E0 | 9'h015, 9'h1FF, 1'b0);
    idle(1);
    // R7 completion and next acceptance on adjacent edges
    run_char(1'b0, 1'b1, 2'd1, 1'b0, 1, 9'h02D, 9'h012, 1'b0);
    run_char(1'b1, 1'b0, 2'd3, 1'b1, 3, 9'h133, 9'h0CC, 1'b0);
    idle(2);
    // R8 configuration and transmit request disturbed mid-character
    run_char(1'b0, 1'b1, 2'd2, 1'b0, 2, 9'h05B, 9'h024, 1'b1);
    idle(3);
    run_char(1'b1, 1'b0, 2'd1, 1'b1, 4, 9'h0E7, 9'h118, 1'b1);
    idle(3);
    // constrained random mix
    for (int i = 0; i < 40; i++) begin
      len = 2'($urandom);
      run_char(1'($urandom), 1'($urandom), len, ($urandom % 4) == 0,
               int'($urandom % 5), 9'($urandom), 9'($urandom), ($urandom % 6) == 0);
      if ($urandom % 3 != 0) idle(1 + int'($urandom % 3));
    end
    idle(2);
    report;
    $finish;
  end

endmodule